// File: doc/BRIEF.md
# Quad-Enable Bit Sequencer for Serial NOR Flash

This block sets the quad-enable bit of a serial NOR flash before the host switches to four-wire transfers. A 3-bit mode code says where the device keeps that bit and how it must be written. On a start pulse the sequencer latches the code. It first reads the register that holds the bit. If the bit is already set, it stops there. If not, it sends write-enable and the register write. It then polls the write-in-progress flag and reads the register back to confirm the bit took effect.

The sequencer talks to a byte-level command port. Each command carries an opcode, a read flag, a write byte count (0, 1 or 2) and up to two write bytes. The command is framed by an active-low chip select and is held until the serializer answers with a one-cycle `cmd_done` pulse, which also carries the read byte. Bit-level shifting is done outside this block. At the end, `done` pulses once, and `error` and `already_set` report how the sequence ended.

Top module: `quad_enable_seq`

## Requirements
- R1: Mode codes 000, 110 and 111 issue no command. `busy` is high for exactly one cycle, then `done` pulses with `error` and `already_set` low.
- R2: Mode 011 reads with opcode 0x3F and tests bit 7. If the bit is clear, it sends 0x06 and then opcode 0x3E with one byte equal to the read value with bit 7 set.
- R3: Modes 001, 100 and 101 read with opcode 0x35 and test bit 1. If the bit is clear, they read 0x05, send 0x06, and then send 0x01 with two bytes: first the status byte unchanged, second the 0x35 value with bit 1 set.
- R4: Mode 010 reads with opcode 0x05 and tests bit 6. If the bit is clear, it sends 0x06 and then 0x01 with one byte equal to the read value with bit 6 set.
- R5: If the bit is found set at the first read, the sequence ends after that one command. `already_set` is 1 and `error` is 0.
- R6: After the write, opcode 0x05 is polled until read bit 0 is 0. The register is then read back with the first read's opcode, and `error` is set if the bit is still clear.
- R7: If `poll_limit` consecutive polls (at least one) all return bit 0 set, the sequence ends with `error` = 1 and no read-back.
- R8: `cmd_valid` is high exactly while `cs_n` is low. A command stays unchanged until `cmd_done`. `cs_n` is high for at least GAP_CYC cycles after each `cmd_done`.
- R9: `busy` rises in the cycle after `start` is taken in idle and stays high until `done`. `done` is a one-cycle pulse in the first cycle `busy` is low. A `start` pulse while busy is ignored.
- R10: `error` and `already_set` are cleared by reset and by an accepted `start`. Otherwise they hold their values after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| mode_code | input | 3 | Bit location / write method code |
| poll_limit | input | POLL_W | Maximum busy polls before timeout |
| cmd_valid | output | 1 | Command presented to serializer |
| cs_n | output | 1 | Active-low chip select |
| cmd_op | output | 8 | Command opcode |
| cmd_rd | output | 1 | Command returns one data byte |
| cmd_wcnt | output | 2 | Number of write data bytes |
| cmd_wd0 | output | 8 | First write byte |
| cmd_wd1 | output | 8 | Second write byte |
| cmd_done | input | 1 | Serializer finished the command |
| cmd_rdata | input | 8 | Read byte, valid with cmd_done |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Verify failure or poll timeout |
| already_set | output | 1 | Bit found set on first read |

## Verification
The cases that are hard to reach are the two failure paths. In one, the write is accepted but the bit does not change. In the other, the write-in-progress flag outlasts the poll budget, including a budget of zero. The bench's flash model can be told to ignore writes to the quad-enable bit, and it reports busy for a chosen number of polls after each write. This lets a verify failure and a timeout at an exact poll count be produced on purpose. A second start pulse is also injected in the middle of a sequence, to show that it changes neither the command stream nor the flags.

// File: rtl/qen_pkg.sv
package qen_pkg;

   localparam logic [7:0] OP_RD_SR1  = 8'h05;
   localparam logic [7:0] OP_WR_EN   = 8'h06;
   localparam logic [7:0] OP_WR_STAT = 8'h01;
   localparam logic [7:0] OP_RD_CFG  = 8'h35;
   localparam logic [7:0] OP_RD_SR2  = 8'h3F;
   localparam logic [7:0] OP_WR_SR2  = 8'h3E;

   typedef enum logic [3:0] {
      ST_IDLE, ST_CHK, ST_SR1, ST_WREN, ST_WR, ST_POLL, ST_VFY, ST_GAP, ST_FIN
   } qen_step_t;

   typedef struct packed {
      logic       act;
      logic       two_byte;
      logic [7:0] rd_op;
      logic [7:0] wr_op;
      logic [7:0] mask;
   } qen_route_t;

endpackage

// File: rtl/qen_route.sv
module qen_route
   import qen_pkg::*;
(
   input  logic [2:0] code,
   output qen_route_t route
);

   always_comb begin
      route = '0;
      unique case (code)
         3'b001, 3'b100, 3'b101: begin
            route.act      = 1'b1;
            route.two_byte = 1'b1;
            route.rd_op    = OP_RD_CFG;
            route.wr_op    = OP_WR_STAT;
            route.mask     = 8'h02;
         end
         3'b010: begin
            route.act   = 1'b1;
            route.rd_op = OP_RD_SR1;
            route.wr_op = OP_WR_STAT;
            route.mask  = 8'h40;
         end
         3'b011: begin
            route.act   = 1'b1;
            route.rd_op = OP_RD_SR2;
            route.wr_op = OP_WR_SR2;
            route.mask  = 8'h80;
         end
         default: route = '0;
      endcase
   end

endmodule

// File: rtl/qen_poll_ctr.sv
module qen_poll_ctr #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   input  logic [W-1:0] limit,
   output logic         last
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= cnt + 1'b1;
   end

   assign last = ({1'b0, cnt} + 1'b1) >= {1'b0, limit};

   // R7
   cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr) |=> (cnt != '0));

endmodule

// File: rtl/quad_enable_seq.sv
module quad_enable_seq
   import qen_pkg::*;
#(
   parameter int POLL_W  = 8,
   parameter int GAP_CYC = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        mode_code,
   input  logic [POLL_W-1:0] poll_limit,
   output logic              cmd_valid,
   output logic              cs_n,
   output logic [7:0]        cmd_op,
   output logic              cmd_rd,
   output logic [1:0]        cmd_wcnt,
   output logic [7:0]        cmd_wd0,
   output logic [7:0]        cmd_wd1,
   input  logic              cmd_done,
   input  logic [7:0]        cmd_rdata,
   output logic              busy,
   output logic              done,
   output logic              error,
   output logic              already_set
);

   if (POLL_W < 1 || POLL_W > 24) begin : g_bad_pw
      $error("POLL_W out of range");
   end
   if (GAP_CYC < 1) begin : g_bad_gap
      $error("GAP_CYC must be at least 1");
   end

   qen_step_t  state, nxt_q;
   logic [2:0] code_q;
   logic [7:0] qe_val, sr1_q;
   logic       poll_last, gap_ok, bit_hit;
   qen_route_t route;

   qen_route u_route (
      .code  (state == ST_IDLE ? mode_code : code_q),
      .route (route)
   );

   qen_poll_ctr #(.W(POLL_W)) u_poll (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (state == ST_WR),
      .inc   (state == ST_POLL && cmd_done && cmd_rdata[0] && !poll_last),
      .limit (poll_limit),
      .last  (poll_last)
   );

   if (GAP_CYC == 1) begin : g_gap_one
      assign gap_ok = 1'b1;
   end else begin : g_gap_cnt
      localparam int GW = $clog2(GAP_CYC);
      logic [GW-1:0] gcnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               gcnt <= '0;
         else if (state != ST_GAP) gcnt <= '0;
         else                      gcnt <= gcnt + 1'b1;
      end
      assign gap_ok = (gcnt == GW'(GAP_CYC - 1));
   end

   assign bit_hit = (cmd_rdata & route.mask) != 8'd0;

   always_comb begin
      cmd_valid = 1'b1;
      cmd_op    = 8'h00;
      cmd_rd    = 1'b0;
      cmd_wcnt  = 2'd0;
      cmd_wd0   = 8'h00;
      cmd_wd1   = 8'h00;
      unique case (state)
         ST_CHK:  begin cmd_op = route.rd_op; cmd_rd = 1'b1; end
         ST_SR1:  begin cmd_op = OP_RD_SR1;   cmd_rd = 1'b1; end
         ST_WREN: cmd_op = OP_WR_EN;
         ST_WR: begin
            cmd_op = route.wr_op;
            if (route.two_byte) begin
               cmd_wcnt = 2'd2;
               cmd_wd0  = sr1_q;
               cmd_wd1  = qe_val | route.mask;
            end else begin
               cmd_wcnt = 2'd1;
               cmd_wd0  = qe_val | route.mask;
            end
         end
         ST_POLL: begin cmd_op = OP_RD_SR1;   cmd_rd = 1'b1; end
         ST_VFY:  begin cmd_op = route.rd_op; cmd_rd = 1'b1; end
         default: cmd_valid = 1'b0;
      endcase
   end

   assign cs_n = !cmd_valid;
   assign busy = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         nxt_q       <= ST_IDLE;
         code_q      <= '0;
         qe_val      <= '0;
         sr1_q       <= '0;
         done        <= 1'b0;
         error       <= 1'b0;
         already_set <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: if (start) begin
               code_q      <= mode_code;
               error       <= 1'b0;
               already_set <= 1'b0;
               state       <= route.act ? ST_CHK : ST_FIN;
            end
            ST_CHK: if (cmd_done) begin
               qe_val <= cmd_rdata;
               if (bit_hit) begin
                  already_set <= 1'b1;
                  state       <= ST_FIN;
               end else begin
                  nxt_q <= route.two_byte ? ST_SR1 : ST_WREN;
                  state <= ST_GAP;
               end
            end
            ST_SR1: if (cmd_done) begin
               sr1_q <= cmd_rdata;
               nxt_q <= ST_WREN;
               state <= ST_GAP;
            end
            ST_WREN: if (cmd_done) begin
               nxt_q <= ST_WR;
               state <= ST_GAP;
            end
            ST_WR: if (cmd_done) begin
               nxt_q <= ST_POLL;
               state <= ST_GAP;
            end
            ST_POLL: if (cmd_done) begin
               if (!cmd_rdata[0]) begin
                  nxt_q <= ST_VFY;
                  state <= ST_GAP;
               end else if (poll_last) begin
                  error <= 1'b1;
                  state <= ST_FIN;
               end else begin
                  nxt_q <= ST_POLL;
                  state <= ST_GAP;
               end
            end
            ST_VFY: if (cmd_done) begin
               error <= !bit_hit;
               state <= ST_FIN;
            end
            ST_GAP: if (gap_ok) state <= nxt_q;
            ST_FIN: begin
               done  <= 1'b1;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R8
   gap_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_done) |=> cs_n);

   // R8
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_op)));

   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R5
   flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !(error && already_set));

   // R1
   none_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && (mode_code == 3'b000 || mode_code[2:1] == 2'b11))
         |=> (busy && !cmd_valid) ##1 done);

   // R2
   sr2_write_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_WR_SR2) |-> (code_q == 3'b011));

endmodule

// File: tb/test_quad_enable_seq.sv
module test_quad_enable_seq;

   localparam int PW  = 8;
   localparam int LAT = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [2:0]    mode_code = 3'b000;
   logic [PW-1:0] poll_limit = '0;
   logic          cmd_valid, cs_n, cmd_rd;
   logic [7:0]    cmd_op, cmd_wd0, cmd_wd1;
   logic [1:0]    cmd_wcnt;
   logic          cmd_done = 1'b0;
   logic [7:0]    cmd_rdata = 8'h00;
   logic          busy, done, error, already_set;

   always #2ns clk = ~clk;

   quad_enable_seq #(.POLL_W(PW), .GAP_CYC(1)) i_quad_enable_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .mode_code(mode_code),
      .poll_limit(poll_limit), .cmd_valid(cmd_valid), .cs_n(cs_n),
      .cmd_op(cmd_op), .cmd_rd(cmd_rd), .cmd_wcnt(cmd_wcnt),
      .cmd_wd0(cmd_wd0), .cmd_wd1(cmd_wd1), .cmd_done(cmd_done),
      .cmd_rdata(cmd_rdata), .busy(busy), .done(done), .error(error),
      .already_set(already_set)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // flash model state
   logic [7:0]  f_sr1, f_sr2, f_cr;
   bit          f_wel, f_stuck;
   int          f_busyn, f_busy_left;
   logic [31:0] log_q[$];

   function automatic logic [31:0] ent(input logic [7:0] op, input bit rd,
                                       input logic [1:0] wc,
                                       input logic [7:0] d0, input logic [7:0] d1);
      return {op, 5'd0, rd, wc, d0, d1};
   endfunction

   // serializer + flash responder
   initial begin
      int lat = 0;
      forever begin
         @(negedge clk);
         if (cmd_done) begin
            cmd_done = 1'b0;
         end else if (cmd_valid) begin
            if (lat == LAT) begin
               lat = 0;
               log_q.push_back(ent(cmd_op, cmd_rd, cmd_wcnt,
                                   cmd_wcnt >= 2'd1 ? cmd_wd0 : 8'h00,
                                   cmd_wcnt == 2'd2 ? cmd_wd1 : 8'h00));
               cmd_rdata = 8'h00;
               case (cmd_op)
                  8'h05: begin
                     cmd_rdata = {f_sr1[7:1], f_busy_left != 0};
                     if (f_busy_left != 0) f_busy_left--;
                  end
                  8'h35: cmd_rdata = f_cr;
                  8'h3F: cmd_rdata = f_sr2;
                  8'h06: f_wel = 1'b1;
                  8'h01: if (f_wel) begin
                     f_sr1 = f_stuck ? {cmd_wd0[7], f_sr1[6], cmd_wd0[5:1], 1'b0}
                                     : {cmd_wd0[7:1], 1'b0};
                     if (cmd_wcnt == 2'd2)
                        f_cr = f_stuck ? {cmd_wd1[7:2], f_cr[1], cmd_wd1[0]} : cmd_wd1;
                     f_wel = 1'b0;
                     f_busy_left = f_busyn;
                  end
                  8'h3E: if (f_wel) begin
                     f_sr2 = f_stuck ? {f_sr2[7], cmd_wd0[6:0]} : cmd_wd0;
                     f_wel = 1'b0;
                     f_busy_left = f_busyn;
                  end
                  default: ;
               endcase
               cmd_done = 1'b1;
            end else begin
               lat++;
            end
         end
      end
   end

   // per-clock protocol monitor
   initial begin
      bit p_done_cmd = 0, p_valid = 0, p_busy = 0, p_start = 0;
      logic [7:0] p_op = 8'h00;
      forever begin
         @(negedge clk);
         #1;
         if (rst_n) begin
            chk(cmd_valid == !cs_n, "R8", "valid vs cs_n", {31'd0, cmd_valid}, {31'd0, !cs_n});
            if (p_done_cmd) chk(cs_n, "R8", "cs_n gap", {31'd0, cs_n}, 32'd1);
            if (p_valid && !p_done_cmd)
               chk(cmd_valid && cmd_op == p_op, "R8", "command hold", {24'd0, cmd_op}, {24'd0, p_op});
            if (done) chk(!busy && p_busy, "R9", "done vs busy", {31'd0, busy}, 32'd0);
            if (!busy && p_busy) chk(done, "R9", "done at busy fall", {31'd0, done}, 32'd1);
            if (busy && !p_busy) chk(p_start, "R9", "busy rise cause", {31'd0, p_start}, 32'd1);
            if (p_start && !p_busy) chk(busy, "R9", "busy after start", {31'd0, busy}, 32'd1);
            p_done_cmd = cmd_valid && cmd_done;
            p_valid    = cmd_valid;
            p_op       = cmd_op;
            p_busy     = busy;
            p_start    = start;
         end
      end
   end

   // expectation model
   logic [31:0] exp_q[$];
   bit          e_err, e_set;
   logic [7:0]  e_sr1, e_sr2, e_cr;

   task automatic exp_polls(input int busyn, input int limit, input logic [7:0] vop, input bit stuck);
      int lim = (limit == 0) ? 1 : limit;
      if (busyn >= lim) begin
         repeat (lim) exp_q.push_back(ent(8'h05, 1, 2'd0, 8'h00, 8'h00));
         e_err = 1;
      end else begin
         repeat (busyn + 1) exp_q.push_back(ent(8'h05, 1, 2'd0, 8'h00, 8'h00));
         exp_q.push_back(ent(vop, 1, 2'd0, 8'h00, 8'h00));
         e_err = stuck;
      end
   endtask

   task automatic compute_exp(input logic [2:0] code, input logic [7:0] sr1, input logic [7:0] sr2,
                              input logic [7:0] cr, input int busyn, input int limit, input bit stuck);
      exp_q.delete();
      e_err = 0; e_set = 0;
      e_sr1 = sr1; e_sr2 = sr2; e_cr = cr;
      case (code)
         3'b011: begin
            exp_q.push_back(ent(8'h3F, 1, 2'd0, 8'h00, 8'h00));
            if (sr2[7]) e_set = 1;
            else begin
               exp_q.push_back(ent(8'h06, 0, 2'd0, 8'h00, 8'h00));
               exp_q.push_back(ent(8'h3E, 0, 2'd1, sr2 | 8'h80, 8'h00));
               if (!stuck) e_sr2 = sr2 | 8'h80;
               exp_polls(busyn, limit, 8'h3F, stuck);
            end
         end
         3'b001, 3'b100, 3'b101: begin
            exp_q.push_back(ent(8'h35, 1, 2'd0, 8'h00, 8'h00));
            if (cr[1]) e_set = 1;
            else begin
               exp_q.push_back(ent(8'h05, 1, 2'd0, 8'h00, 8'h00));
               exp_q.push_back(ent(8'h06, 0, 2'd0, 8'h00, 8'h00));
               exp_q.push_back(ent(8'h01, 0, 2'd2, sr1, cr | 8'h02));
               if (!stuck) e_cr = cr | 8'h02;
               exp_polls(busyn, limit, 8'h35, stuck);
            end
         end
         3'b010: begin
            exp_q.push_back(ent(8'h05, 1, 2'd0, 8'h00, 8'h00));
            if (sr1[6]) e_set = 1;
            else begin
               exp_q.push_back(ent(8'h06, 0, 2'd0, 8'h00, 8'h00));
               exp_q.push_back(ent(8'h01, 0, 2'd1, sr1 | 8'h40, 8'h00));
               if (!stuck) e_sr1 = sr1 | 8'h40;
               exp_polls(busyn, limit, 8'h05, stuck);
            end
         end
         default: ;
      endcase
   endtask

   task automatic run(input logic [2:0] code, input logic [7:0] sr1, input logic [7:0] sr2,
                      input logic [7:0] cr, input int busyn, input int limit,
                      input bit stuck, input bit poke, input string req);
      int bcnt = 0;
      bit got = 0;
      f_sr1 = sr1; f_sr2 = sr2; f_cr = cr; f_stuck = stuck;
      f_busyn = busyn; f_busy_left = 0; f_wel = 0;
      log_q.delete();
      poll_limit = PW'(limit);
      compute_exp(code, sr1, sr2, cr, busyn, limit, stuck);
      @(negedge clk);
      start = 1'b1;
      mode_code = code;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         start = poke && (i == 3);
         if (poke && i == 3) mode_code = 3'b010;
         #1;
         if (i == 0)
            chk(!error && !already_set, "R10", "flags cleared on start",
                {30'd0, error, already_set}, 32'd0);
         if (busy) bcnt++;
         if (done) begin got = 1; break; end
      end
      start = 1'b0;
      chk(got, req, "done reached", {31'd0, got}, 32'd1);
      chk(error == e_err, req, "error flag", {31'd0, error}, {31'd0, e_err});
      chk(already_set == e_set, req, "already_set flag", {31'd0, already_set}, {31'd0, e_set});
      chk(log_q.size() == exp_q.size(), req, "command count", log_q.size(), exp_q.size());
      for (int k = 0; k < exp_q.size() && k < log_q.size(); k++)
         chk(log_q[k] == exp_q[k], req, $sformatf("command %0d", k), log_q[k], exp_q[k]);
      chk({f_sr1, f_sr2, f_cr} == {e_sr1, e_sr2, e_cr}, req, "flash registers",
          {8'd0, f_sr1, f_sr2, f_cr}, {8'd0, e_sr1, e_sr2, e_cr});
      if (code == 3'b000 || code[2:1] == 2'b11)
         chk(bcnt == 1, "R1", "busy cycles", bcnt, 1);
      repeat (3) @(negedge clk);
      #1;
      chk(!busy && !done, "R9", "quiet after done", {30'd0, busy, done}, 32'd0);
   endtask

   // watchdog
   initial begin
      #(200000 * 4ns);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      #1;
      chk(!busy && !done && cs_n && !cmd_valid && !error && !already_set, "R10",
          "reset state", {27'd0, busy, done, cs_n, error, already_set}, 32'h4);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      run(3'b000, 8'h00, 8'h00, 8'h00, 0, 4, 0, 0, "R1");
      run(3'b110, 8'h00, 8'h00, 8'h00, 0, 4, 0, 0, "R1");
      run(3'b111, 8'h00, 8'h00, 8'h00, 0, 4, 0, 0, "R1");
      run(3'b011, 8'h00, 8'h21, 8'h00, 2, 8, 0, 0, "R2");
      run(3'b011, 8'h00, 8'hA0, 8'h00, 0, 8, 0, 0, "R5");
      run(3'b101, 8'h5C, 8'h00, 8'h41, 0, 4, 0, 0, "R3");
      run(3'b001, 8'h10, 8'h00, 8'h00, 1, 4, 0, 0, "R3");
      run(3'b100, 8'h80, 8'h00, 8'h0C, 3, 4, 0, 0, "R3");
      run(3'b101, 8'h00, 8'h00, 8'h02, 0, 4, 0, 0, "R5");
      run(3'b010, 8'h0C, 8'h00, 8'h00, 3, 10, 0, 0, "R4");
      run(3'b010, 8'h42, 8'h00, 8'h00, 0, 4, 0, 0, "R5");
      run(3'b011, 8'h00, 8'h00, 8'h00, 0, 4, 1, 0, "R6");
      repeat (5) @(negedge clk);
      #1;
      chk(error, "R10", "error held after done", {31'd0, error}, 32'd1);
      run(3'b101, 8'h24, 8'h00, 8'h10, 1, 4, 1, 0, "R6");
      run(3'b101, 8'h00, 8'h00, 8'h00, 5, 3, 0, 0, "R7");
      run(3'b010, 8'h04, 8'h00, 8'h00, 1, 0, 0, 0, "R7");
      run(3'b011, 8'h00, 8'h01, 8'h00, 1, 4, 0, 1, "R9");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule